// File: doc/BRIEF.md
# Mixed-Size Bank Chip-Enable Decoder

This block converts the high-order bits of a memory card's common-memory address into eight active-low chip enables, one per bank of external memory devices. It offers two decoding schemes. In uniform mode, a 3-bit bank field picks one of eight equally sized banks. In mixed mode, banks of two different sizes share one contiguous address map. A 2-bit size-select field either routes the two low bank bits to one of the four small banks or picks one of the three large banks directly. As a result, bank 4 is never reachable in mixed mode.

Banks are enabled only for common-memory cycles, and only when at least one of the two card byte enables is low. The mode and size-select inputs are pulled high when they are not driven, so an unconnected board selects uniform decoding. The output can be registered, which is the default, or left combinational through a parameter. When it is registered, an asynchronous active-low reset forces every enable high.

Top module: `bce_decoder`

## Requirements
- R1: With `single_mode` high, `bank_addr` value k (0 to 7) drives exactly `bank_ce_n[k]` low and all other bits high.
- R2: With `single_mode` high, `size_sel` has no effect on `bank_ce_n`.
- R3: With `single_mode` low and `size_sel` = 2'b00, `bank_addr[1:0]` value k drives `bank_ce_n[k]` (k = 0 to 3) low, and `bank_addr[2]` has no effect.
- R4: With `single_mode` low, `size_sel` values 2'b01, 2'b10 and 2'b11 drive `bank_ce_n[5]`, `bank_ce_n[6]` and `bank_ce_n[7]` low respectively, whatever `bank_addr` holds.
- R5: With `single_mode` low, `bank_ce_n[4]` is never low.
- R6: With `common_sel` low (attribute access), all bits of `bank_ce_n` are high.
- R7: With both `card_en_lo_n` and `card_en_hi_n` high, all bits of `bank_ce_n` are high. Either one low alone is enough to enable decoding.
- R8: At most one bit of `bank_ce_n` is low in any cycle.
- R9: With the output registered (the default), `bank_ce_n` shows the decode of the inputs sampled at the previous rising `clk` edge. While `rst_n` is low, `bank_ce_n` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| single_mode | input | 1 | High: uniform one-of-eight decode. Low: mixed-size decode. Reads high when undriven |
| size_sel | input | 2 | Mixed-mode group select. Reads high when undriven |
| bank_addr | input | 3 | Bank field taken from the high-order card address |
| common_sel | input | 1 | High for a common-memory access, low for an attribute access |
| card_en_lo_n | input | 1 | Active-low even-byte card enable |
| card_en_hi_n | input | 1 | Active-low odd-byte card enable |
| bank_ce_n | output | 8 | Active-low bank chip enables |

## Verification
The bank decode and the access gating act in the same cycle. A valid bank selection can coincide with an attribute access, or with both card enables idle. The table drives vectors that would select a bank under each decoding mode while one gating condition holds, and the result is judged correct only if all eight enables stay high. A second overlap, between the output register's reset and a live selection, is provoked by asserting reset while a bank is enabled. Then all enables must go high at once, with no clock edge.

// File: rtl/bce_pkg.sv
package bce_pkg;

    // Decoding scheme chosen by the mode input
    typedef enum logic {
        MODE_MIXED   = 1'b0,
        MODE_UNIFORM = 1'b1
    } bce_mode_e;

    // An input left floating or unknown reads as logic high
    function automatic logic pull_high(input logic b);
        return (b === 1'b0) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/bce_input_norm.sv
module bce_input_norm #(
    parameter int SEL_W = 2
) (
    input  logic             mode_raw,
    input  logic [SEL_W-1:0] sel_raw,
    output bce_pkg::bce_mode_e mode,
    output logic [SEL_W-1:0] sel
);
    import bce_pkg::*;

    always_comb begin
        mode = bce_mode_e'(pull_high(mode_raw));
    end

    for (genvar i = 0; i < SEL_W; i++) begin : g_sel
        always_comb sel[i] = pull_high(sel_raw[i]);
    end
endmodule

// File: rtl/bce_uniform_dec.sv
module bce_uniform_dec #(
    parameter int ADDR_W = 3,
    localparam int BANKS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANKS-1:0]  hot
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_comb hot[b] = (addr == ADDR_W'(b));
    end
endmodule

// File: rtl/bce_mixed_dec.sv
module bce_mixed_dec #(
    parameter int ADDR_W = 3,
    parameter int SEL_W  = 2,
    localparam int BANKS     = 1 << ADDR_W,
    localparam int LOW_W     = ADDR_W - 1,
    localparam int LOW_BANKS = 1 << LOW_W,
    localparam int TOP_BASE  = BANKS - (1 << SEL_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  sel,
    output logic [BANKS-1:0]  hot
);
    logic small_grp;
    always_comb small_grp = (sel == '0);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        if (b < LOW_BANKS) begin : g_small
            always_comb hot[b] = small_grp && (addr[LOW_W-1:0] == LOW_W'(b));
        end else if (b > TOP_BASE) begin : g_large
            always_comb hot[b] = (sel == SEL_W'(b - TOP_BASE));
        end else begin : g_dead
            always_comb hot[b] = 1'b0;
        end
    end
endmodule

// File: rtl/bce_decoder.sv
module bce_decoder #(
    parameter int ADDR_W       = 3,
    parameter int SEL_W        = 2,
    parameter bit REGISTER_OUT = 1'b1,
    localparam int BANKS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_mode,
    input  logic [SEL_W-1:0]  size_sel,
    input  logic [ADDR_W-1:0] bank_addr,
    input  logic              common_sel,
    input  logic              card_en_lo_n,
    input  logic              card_en_hi_n,
    output logic [BANKS-1:0]  bank_ce_n
);
    import bce_pkg::*;

    bce_mode_e         mode;
    logic [SEL_W-1:0]  sel;
    logic [BANKS-1:0]  hot_uni;
    logic [BANKS-1:0]  hot_mix;
    logic [BANKS-1:0]  hot;
    logic              access_ok;
    logic [BANKS-1:0]  ce_n_next;

    bce_input_norm #(.SEL_W(SEL_W)) u_norm (
        .mode_raw (single_mode),
        .sel_raw  (size_sel),
        .mode     (mode),
        .sel      (sel)
    );

    bce_uniform_dec #(.ADDR_W(ADDR_W)) u_uni (
        .addr (bank_addr),
        .hot  (hot_uni)
    );

    bce_mixed_dec #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_mix (
        .addr (bank_addr),
        .sel  (sel),
        .hot  (hot_mix)
    );

    always_comb begin
        access_ok = common_sel && !(card_en_lo_n && card_en_hi_n);
        unique case (mode)
            MODE_UNIFORM: hot = hot_uni;
            MODE_MIXED:   hot = hot_mix;
            default:      hot = '0;
        endcase
        ce_n_next = access_ok ? ~hot : '1;
    end

    if (REGISTER_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_ce_n <= '1;
            else        bank_ce_n <= ce_n_next;
        end
    end else begin : g_comb
        always_comb bank_ce_n = ce_n_next;
    end
endmodule

// File: rtl/bce_decoder_chk.sv
module bce_decoder_chk #(
    parameter int ADDR_W       = 3,
    parameter int SEL_W        = 2,
    parameter bit REGISTER_OUT = 1'b1,
    localparam int BANKS = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              single_mode,
    input logic [SEL_W-1:0]  size_sel,
    input logic [ADDR_W-1:0] bank_addr,
    input logic              common_sel,
    input logic              card_en_lo_n,
    input logic              card_en_hi_n,
    input logic [BANKS-1:0]  bank_ce_n
);
    AST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bank_ce_n) <= 1); // R8

    if (REGISTER_OUT) begin : g_seq
        AST_ATTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(common_sel)) |-> (&bank_ce_n)); // R6
        AST_CARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(card_en_lo_n) && $past(card_en_hi_n)) |-> (&bank_ce_n)); // R7
        AST_MIXED_NO_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(single_mode)) |-> bank_ce_n[4]); // R5
        AST_UNIFORM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(single_mode) && $past(common_sel) && !$past(card_en_lo_n))
            |-> !bank_ce_n[$past(bank_addr)]); // R1
        AST_MIXED_LARGE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(single_mode) && $past(common_sel) && !$past(card_en_hi_n)
             && ($past(size_sel) == 2'b11)) |-> !bank_ce_n[7]); // R4
    end else begin : g_comb
        AST_ATTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !common_sel |-> (&bank_ce_n)); // R6
        AST_CARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (card_en_lo_n && card_en_hi_n) |-> (&bank_ce_n)); // R7
        AST_MIXED_NO_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
            !single_mode |-> bank_ce_n[4]); // R5
        AST_UNIFORM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (single_mode && common_sel && !card_en_lo_n) |-> !bank_ce_n[bank_addr]); // R1
    end
endmodule

bind bce_decoder bce_decoder_chk #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .REGISTER_OUT(REGISTER_OUT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .single_mode  (single_mode),
    .size_sel     (size_sel),
    .bank_addr    (bank_addr),
    .common_sel   (common_sel),
    .card_en_lo_n (card_en_lo_n),
    .card_en_hi_n (card_en_hi_n),
    .bank_ce_n    (bank_ce_n)
);

// File: tb/tb_bce_decoder.sv
module tb_bce_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       single_mode = 1'b1;
    logic [1:0] size_sel = 2'b11;
    logic [2:0] bank_addr = 3'd0;
    logic       common_sel = 1'b1;
    logic       card_en_lo_n = 1'b1;
    logic       card_en_hi_n = 1'b1;
    logic [7:0] bank_ce_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bce_decoder dut (
        .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .size_sel(size_sel),
        .bank_addr(bank_addr), .common_sel(common_sel), .card_en_lo_n(card_en_lo_n),
        .card_en_hi_n(card_en_hi_n), .bank_ce_n(bank_ce_n)
    );

    // {req, single, sel, addr, common, lo_n, hi_n, expected}
    localparam int NV = 22;
    localparam logic [20:0] VEC [NV] = '{
        {4'd1, 1'b1, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1, 8'hFE},  // R1
        {4'd1, 1'b1, 2'b00, 3'd3, 1'b1, 1'b0, 1'b1, 8'hF7},  // R1
        {4'd1, 1'b1, 2'b11, 3'd4, 1'b1, 1'b1, 1'b0, 8'hEF},  // R1
        {4'd1, 1'b1, 2'b01, 3'd7, 1'b1, 1'b0, 1'b0, 8'h7F},  // R1
        {4'd2, 1'b1, 2'b10, 3'd5, 1'b1, 1'b0, 1'b1, 8'hDF},  // R2
        {4'd2, 1'b1, 2'b00, 3'd5, 1'b1, 1'b0, 1'b1, 8'hDF},  // R2
        {4'd3, 1'b0, 2'b00, 3'd0, 1'b1, 1'b0, 1'b1, 8'hFE},  // R3
        {4'd3, 1'b0, 2'b00, 3'd1, 1'b1, 1'b0, 1'b1, 8'hFD},  // R3
        {4'd3, 1'b0, 2'b00, 3'd6, 1'b1, 1'b0, 1'b1, 8'hFB},  // R3
        {4'd3, 1'b0, 2'b00, 3'd7, 1'b1, 1'b1, 1'b0, 8'hF7},  // R3
        {4'd4, 1'b0, 2'b01, 3'd0, 1'b1, 1'b0, 1'b1, 8'hDF},  // R4
        {4'd4, 1'b0, 2'b10, 3'd5, 1'b1, 1'b0, 1'b1, 8'hBF},  // R4
        {4'd4, 1'b0, 2'b11, 3'd2, 1'b1, 1'b0, 1'b0, 8'h7F},  // R4
        {4'd5, 1'b0, 2'b11, 3'd4, 1'b1, 1'b0, 1'b1, 8'h7F},  // R5
        {4'd5, 1'b0, 2'b00, 3'd4, 1'b1, 1'b0, 1'b1, 8'hFE},  // R5
        {4'd6, 1'b1, 2'b11, 3'd2, 1'b0, 1'b0, 1'b1, 8'hFF},  // R6
        {4'd6, 1'b0, 2'b11, 3'd0, 1'b0, 1'b0, 1'b0, 8'hFF},  // R6
        {4'd6, 1'b0, 2'b00, 3'd1, 1'b0, 1'b1, 1'b0, 8'hFF},  // R6
        {4'd7, 1'b1, 2'b11, 3'd2, 1'b1, 1'b1, 1'b1, 8'hFF},  // R7
        {4'd7, 1'b0, 2'b10, 3'd2, 1'b1, 1'b1, 1'b1, 8'hFF},  // R7
        {4'd7, 1'b1, 2'b11, 3'd2, 1'b1, 1'b1, 1'b0, 8'hFB},  // R7
        {4'd7, 1'b1, 2'b11, 3'd2, 1'b1, 1'b0, 1'b0, 8'hFB}   // R7
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] exp, input string what);
        checks++;
        if (bank_ce_n !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, bank_ce_n, exp);
        end
    endtask

    task automatic drive(input logic [20:0] v);
        single_mode  = v[20-4];
        size_sel     = v[15:14];
        bank_addr    = v[13:11];
        common_sel   = v[10];
        card_en_lo_n = v[9];
        card_en_hi_n = v[8];
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int ones_fail;
        // R9: reset state
        repeat (2) @(negedge clk);
        check("R9", 8'hFF, "during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 8'hFF, "after reset, idle inputs");

        // Table walk: drive at falling edge, result after the next rising edge
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(req_name(VEC[i][20:17]), VEC[i][7:0], $sformatf("vector %0d", i));
        end

        // R9: one-edge latency
        drive({4'd1, 1'b1, 2'b11, 3'd6, 1'b1, 1'b0, 1'b1, 8'hBF});
        @(negedge clk);
        check("R9", 8'hBF, "new value after edge");
        drive({4'd1, 1'b1, 2'b11, 3'd1, 1'b1, 1'b0, 1'b1, 8'hFD});
        @(posedge clk);
        #1;
        check("R9", 8'hFD, "updated right after edge");
        bank_addr = 3'd3;
        #2;
        check("R9", 8'hFD, "held between edges");

        // R9: asynchronous reset overrides a live selection
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", 8'hFF, "async reset with bank selected");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 8'hF7, "resume after reset");

        // R8: every input combination yields at most one low enable
        ones_fail = 0;
        for (int c = 0; c < 512; c++) begin
            single_mode  = c[8];
            size_sel     = c[7:6];
            bank_addr    = c[5:3];
            common_sel   = c[2];
            card_en_lo_n = c[1];
            card_en_hi_n = c[0];
            @(negedge clk);
            if ($countones(~bank_ce_n) > 1) begin
                ones_fail++;
                $display("FAIL R8 combo %0d: got %h expected at most one low", c, bank_ce_n);
            end
            // R5: mixed mode never enables bank 4
            if (!c[8] && !bank_ce_n[4]) begin
                ones_fail++;
                $display("FAIL R5 combo %0d: got %h expected bit 4 high", c, bank_ce_n);
            end
        end
        checks++;
        if (ones_fail != 0) errors++;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule